// File: doc/BRIEF.md
# Shadow Stack Write Permission and Fault Checker

This block sits in the store path of a processor core and decides whether a privileged write into the shadow stack may go ahead. It takes one request per valid strobe. Each request carries:

- the current privilege level and the processor mode;
- the control-flow-enforcement enable bits;
- whether a lock prefix was present;
- the operand size;
- the destination linear address with its canonical flag;
- the source data;
- the attribute reply for the target page, which says whether the page is a shadow stack page and whether it belongs to user code.

One cycle later the block gives its answer. It either issues a store request, with the address, the byte-enable mask and the data aligned to the operand size, or it reports a single fault kind.

The block chooses the user control set or the supervisor control set from the privilege level. The write goes ahead only if the global enable, the selected stack enable and the selected write enable are all set. The address must be aligned to the operand size. The target page must be a shadow stack page owned by the matching privilege. When several faults apply, only the one with the highest priority is reported. Page walking, segment limit checks and the memory itself belong to other blocks.

Top module: `sswr_checker`

## Requirements
- R1: At privilege level 3 (`cpl`=3) the user enable pair (`usr_stk_en`, `usr_wr_en`) governs the request. At levels 0 to 2 the supervisor pair (`sup_stk_en`, `sup_wr_en`) governs it, and the other pair has no effect.
- R2: The result is an invalid-opcode fault (`fault_kind`=1) if `cfe_en` is 0, the selected stack enable is 0, or the selected write enable is 0.
- R3: The result is an invalid-opcode fault if `lock_pfx` is 1, or if `cpu_mode` is real-address (0), virtual-8086 (1), or a reserved code (5 to 7). Protected is 2, compatibility is 3 and 64-bit is 4.
- R4: An 8-byte request (`size64`=1) in any mode other than 64-bit (4) is an invalid-opcode fault.
- R5: A general-protection fault (`fault_kind`=2, error code zero) is raised in two cases: an 8-byte request whose address bits [2:0] are not all zero, or a 4-byte request whose address bits [1:0] are not all zero.
- R6: In 64-bit mode, `addr_canonical`=0 raises a general-protection fault. In the other valid modes that flag is ignored.
- R7: A page fault (`fault_kind`=3) is raised if `pg_shadow` is 0, or if `pg_user` differs from (`cpl`==3).
- R8: Only the highest-priority fault is reported. Invalid-opcode comes first, then general-protection, then page fault.
- R9: A store that is allowed drives `store_addr`=`dest_addr`. A 4-byte store uses `store_be`=0x0F and `store_data`={32'b0, `src_data`[31:0]}. An 8-byte store uses `store_be`=0xFF and the full `src_data`.
- R10: `done`, `store_valid` and `fault_valid` come one cycle after `req_valid` and last one cycle. `store_valid` and `fault_valid` are never high together, and none of the three rises without a request.
- R11: While `rst_n` is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 3 | Processor mode code |
| cfe_en | input | 1 | Global control-flow-enforcement enable |
| usr_stk_en | input | 1 | User shadow stack enable |
| usr_wr_en | input | 1 | User shadow stack write enable |
| sup_stk_en | input | 1 | Supervisor shadow stack enable |
| sup_wr_en | input | 1 | Supervisor shadow stack write enable |
| lock_pfx | input | 1 | Lock prefix present |
| size64 | input | 1 | 1 = 8-byte form, 0 = 4-byte form |
| dest_addr | input | ADDR_W | Destination linear address |
| addr_canonical | input | 1 | Address is canonical |
| src_data | input | DATA_W | Source register value |
| pg_shadow | input | 1 | Target page is a shadow stack page |
| pg_user | input | 1 | Target page is owned by user |
| done | output | 1 | Result pulse |
| store_valid | output | 1 | Store request |
| store_addr | output | ADDR_W | Store address |
| store_be | output | DATA_W/8 | Byte-enable mask |
| store_data | output | DATA_W | Store data |
| fault_valid | output | 1 | Fault reported |
| fault_kind | output | 2 | 0 none, 1 invalid-opcode, 2 general-protection, 3 page fault |

## Verification
The bench sets the enable bits of the pair that is not selected to the opposite value. A design that picks its pair from the wrong privilege test would then store where it should fault, or fault where it should store.

It also builds requests that break several rules at once: a lock prefix with a misaligned address and a foreign page, and a misaligned address on a non-shadow page. An inverted priority would report a page fault or a general-protection fault in place of the higher-priority one.

Alignment is probed with an address that is 4-byte aligned but not 8-byte aligned, which catches a mask of the wrong width. A non-canonical address is tried in compatibility mode, which catches a canonical check that is not limited to 64-bit mode. The data of a 4-byte store is checked for upper-half leakage.

// File: rtl/sswr_pkg.sv
// Package: shared codes for the shadow stack write checker.
// Assumes a 3-bit mode code and a 2-bit fault kind at the block edge.
package sswr_pkg;
    typedef enum logic [2:0] {
        MD_REAL   = 3'd0,
        MD_V86    = 3'd1,
        MD_PROT   = 3'd2,
        MD_COMPAT = 3'd3,
        MD_LONG   = 3'd4
    } cpu_mode_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_UD   = 2'd1,
        FK_GP   = 2'd2,
        FK_PF   = 2'd3
    } fault_kind_e;

    localparam logic [1:0] USER_CPL = 2'd3;
endpackage

// File: rtl/sswr_ctrl_sel.sv
// Module: picks the user or the supervisor control pair from the privilege
// level and decides the invalid-opcode condition.
// Assumes: mode codes above the 64-bit code are reserved and are rejected.
module sswr_ctrl_sel
    import sswr_pkg::*;
(
    input  logic [1:0] cpl,
    input  logic [2:0] cpu_mode,
    input  logic       cfe_en,
    input  logic       usr_stk_en,
    input  logic       usr_wr_en,
    input  logic       sup_stk_en,
    input  logic       sup_wr_en,
    input  logic       lock_pfx,
    input  logic       size64,
    output logic       is_user,
    output logic       ud_fault
);
    logic stk_sel;
    logic wr_sel;
    logic mode_ok;
    logic size_ok;

    // Select the enable pair by privilege level.
    always_comb begin
        is_user = (cpl == USER_CPL);
        stk_sel = is_user ? usr_stk_en : sup_stk_en;
        wr_sel  = is_user ? usr_wr_en  : sup_wr_en;
    end

    // Decide whether the mode and the operand size are legal.
    always_comb begin
        mode_ok = (cpu_mode == MD_PROT) || (cpu_mode == MD_COMPAT) ||
                  (cpu_mode == MD_LONG);
        size_ok = !size64 || (cpu_mode == MD_LONG);
    end

    // Collect every invalid-opcode cause.
    always_comb begin
        ud_fault = !cfe_en || !stk_sel || !wr_sel || lock_pfx ||
                   !mode_ok || !size_ok;
    end
endmodule

// File: rtl/sswr_addr_chk.sv
// Module: checks the destination address for size alignment and, in
// 64-bit mode, for canonical form.
// Assumes: the caller passes only the low three address bits.
module sswr_addr_chk
    import sswr_pkg::*;
(
    input  logic [2:0] addr_lo,
    input  logic       size64,
    input  logic [2:0] cpu_mode,
    input  logic       addr_canonical,
    output logic       gp_fault
);
    logic misalign;
    logic noncanon;

    // Alignment mask follows the operand size.
    always_comb begin
        misalign = size64 ? (addr_lo != 3'b000) : (addr_lo[1:0] != 2'b00);
    end

    // Canonical form only matters in 64-bit mode.
    always_comb begin
        noncanon = (cpu_mode == MD_LONG) && !addr_canonical;
        gp_fault = misalign || noncanon;
    end
endmodule

// File: rtl/sswr_page_chk.sv
// Module: checks that the target page is a shadow stack page owned by the
// privilege that issues the write.
// Assumes: the page attribute reply is valid together with the request.
module sswr_page_chk (
    input  logic is_user,
    input  logic pg_shadow,
    input  logic pg_user,
    output logic pf_fault
);
    // Fault on a non-shadow page or on an owner mismatch.
    always_comb begin
        pf_fault = !pg_shadow || (pg_user != is_user);
    end
endmodule

// File: rtl/sswr_checker.sv
// Module: top of the shadow stack write checker. Merges the three checks by
// priority and registers either a store request or one fault kind.
// Assumes: one request per strobe; the result appears on the next cycle.
module sswr_checker
    import sswr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        cpl,
    input  logic [2:0]        cpu_mode,
    input  logic              cfe_en,
    input  logic              usr_stk_en,
    input  logic              usr_wr_en,
    input  logic              sup_stk_en,
    input  logic              sup_wr_en,
    input  logic              lock_pfx,
    input  logic              size64,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic              addr_canonical,
    input  logic [DATA_W-1:0] src_data,
    input  logic              pg_shadow,
    input  logic              pg_user,
    output logic              done,
    output logic              store_valid,
    output logic [ADDR_W-1:0] store_addr,
    output logic [DATA_W/8-1:0] store_be,
    output logic [DATA_W-1:0] store_data,
    output logic              fault_valid,
    output logic [1:0]        fault_kind
);
    localparam int BE_W   = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int HBE_W  = BE_W / 2;

    logic        is_user;
    logic        ud_f;
    logic        gp_f;
    logic        pf_f;
    fault_kind_e kind_n;
    logic [BE_W-1:0]   be_n;
    logic [DATA_W-1:0] data_n;

    sswr_ctrl_sel u_ctrl (
        .cpl        (cpl),
        .cpu_mode   (cpu_mode),
        .cfe_en     (cfe_en),
        .usr_stk_en (usr_stk_en),
        .usr_wr_en  (usr_wr_en),
        .sup_stk_en (sup_stk_en),
        .sup_wr_en  (sup_wr_en),
        .lock_pfx   (lock_pfx),
        .size64     (size64),
        .is_user    (is_user),
        .ud_fault   (ud_f)
    );

    sswr_addr_chk u_addr (
        .addr_lo        (dest_addr[2:0]),
        .size64         (size64),
        .cpu_mode       (cpu_mode),
        .addr_canonical (addr_canonical),
        .gp_fault       (gp_f)
    );

    sswr_page_chk u_page (
        .is_user   (is_user),
        .pg_shadow (pg_shadow),
        .pg_user   (pg_user),
        .pf_fault  (pf_f)
    );

    // Pick the single highest-priority fault.
    always_comb begin
        if (ud_f)      kind_n = FK_UD;
        else if (gp_f) kind_n = FK_GP;
        else if (pf_f) kind_n = FK_PF;
        else           kind_n = FK_NONE;
    end

    // Build the byte mask and the size-trimmed data.
    always_comb begin
        be_n   = size64 ? {BE_W{1'b1}} : {{(BE_W-HBE_W){1'b0}}, {HBE_W{1'b1}}};
        data_n = size64 ? src_data : {{(DATA_W-HALF_W){1'b0}}, src_data[HALF_W-1:0]};
    end

    // Register the result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            store_valid <= 1'b0;
            store_addr  <= '0;
            store_be    <= '0;
            store_data  <= '0;
            fault_valid <= 1'b0;
            fault_kind  <= FK_NONE;
        end else begin
            done        <= req_valid;
            store_valid <= req_valid && (kind_n == FK_NONE);
            fault_valid <= req_valid && (kind_n != FK_NONE);
            fault_kind  <= req_valid ? kind_n : FK_NONE;
            if (req_valid && kind_n == FK_NONE) begin
                store_addr <= dest_addr;
                store_be   <= be_n;
                store_data <= data_n;
            end else begin
                store_addr <= '0;
                store_be   <= '0;
                store_data <= '0;
            end
        end
    end

    // R10: result follows every request by one cycle
    assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    // R10: no output activity without a request
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && !store_valid && !fault_valid));
    // R10: store and fault never together
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_valid && fault_valid));
    // R9: mask is one of the two legal shapes
    assert_be_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        store_valid |-> (store_be == 8'h0F || store_be == 8'hFF));
    // R3: lock prefix always gives invalid-opcode
    assert_lock_ud_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_pfx) |=> (fault_valid && fault_kind == FK_UD));
    // R4: 8-byte form outside 64-bit mode gives invalid-opcode
    assert_size_ud_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size64 && cpu_mode != MD_LONG) |=> (fault_kind == FK_UD));
    // R2: global enable off gives invalid-opcode
    assert_global_ud_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfe_en) |=> (fault_kind == FK_UD));
endmodule

// File: tb/sswr_checker_bench.sv
module sswr_checker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  cpl;
    logic [2:0]  cpu_mode;
    logic        cfe_en, usr_stk_en, usr_wr_en, sup_stk_en, sup_wr_en;
    logic        lock_pfx, size64, addr_canonical, pg_shadow, pg_user;
    logic [63:0] dest_addr, src_data;
    logic        done, store_valid, fault_valid;
    logic [63:0] store_addr, store_data;
    logic [7:0]  store_be;
    logic [1:0]  fault_kind;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sswr_checker u_sswr_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cpl(cpl),
        .cpu_mode(cpu_mode), .cfe_en(cfe_en), .usr_stk_en(usr_stk_en),
        .usr_wr_en(usr_wr_en), .sup_stk_en(sup_stk_en), .sup_wr_en(sup_wr_en),
        .lock_pfx(lock_pfx), .size64(size64), .dest_addr(dest_addr),
        .addr_canonical(addr_canonical), .src_data(src_data),
        .pg_shadow(pg_shadow), .pg_user(pg_user), .done(done),
        .store_valid(store_valid), .store_addr(store_addr), .store_be(store_be),
        .store_data(store_data), .fault_valid(fault_valid), .fault_kind(fault_kind)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // A legal 8-byte user write in 64-bit mode.
    task automatic base_ok();
        cpl = 2'd3; cpu_mode = 3'd4; cfe_en = 1; usr_stk_en = 1; usr_wr_en = 1;
        sup_stk_en = 0; sup_wr_en = 0; lock_pfx = 0; size64 = 1;
        dest_addr = 64'h0000_7fff_0000_1000; addr_canonical = 1;
        src_data = 64'h1122_3344_5566_7788; pg_shadow = 1; pg_user = 1;
    endtask

    // Strobe one request and check the registered result.
    task automatic fire(input string rq, input logic [1:0] kind);
        @(negedge clk); req_valid = 1;
        @(negedge clk); req_valid = 0;
        chk({rq, " done"}, {63'd0, done}, 64'd1);
        chk({rq, " kind"}, {62'd0, fault_kind}, {62'd0, kind});
        chk({rq, " fault_valid"}, {63'd0, fault_valid}, {63'd0, kind != 2'd0});
        chk({rq, " store_valid"}, {63'd0, store_valid}, {63'd0, kind == 2'd0});
    endtask

    task automatic t_reset();
        chk("R11 done", {63'd0, done}, 0);
        chk("R11 store_valid", {63'd0, store_valid}, 0);
        chk("R11 fault_valid", {63'd0, fault_valid}, 0);
        chk("R11 store_be", {56'd0, store_be}, 0);
    endtask

    task automatic t_select();
        base_ok(); fire("R1 user pair used", 2'd0);
        base_ok(); cpl = 2'd0; sup_stk_en = 1; sup_wr_en = 1; usr_stk_en = 0; usr_wr_en = 0;
        pg_user = 0; fire("R1 supervisor pair used", 2'd0);
        base_ok(); cpl = 2'd2; fire("R1 level 2 ignores user pair", 2'd1);
    endtask

    task automatic t_enables();
        base_ok(); cfe_en = 0; fire("R2 global off", 2'd1);
        base_ok(); usr_stk_en = 0; fire("R2 stack enable off", 2'd1);
        base_ok(); usr_wr_en = 0; fire("R2 write enable off", 2'd1);
    endtask

    task automatic t_mode_lock();
        base_ok(); lock_pfx = 1; fire("R3 lock", 2'd1);
        base_ok(); size64 = 0; cpu_mode = 3'd0; fire("R3 real mode", 2'd1);
        base_ok(); size64 = 0; cpu_mode = 3'd1; fire("R3 v86 mode", 2'd1);
        base_ok(); size64 = 0; cpu_mode = 3'd6; fire("R3 reserved mode", 2'd1);
        base_ok(); size64 = 0; cpu_mode = 3'd2; fire("R3 protected 4-byte ok", 2'd0);
        base_ok(); cpu_mode = 3'd3; fire("R4 8-byte in compat", 2'd1);
    endtask

    task automatic t_align();
        base_ok(); dest_addr = 64'h1004; fire("R5 8-byte on 4-aligned", 2'd2);
        base_ok(); size64 = 0; dest_addr = 64'h1004; fire("R5 4-byte on 4-aligned", 2'd0);
        base_ok(); size64 = 0; dest_addr = 64'h1002; fire("R5 4-byte misaligned", 2'd2);
    endtask

    task automatic t_canon();
        base_ok(); addr_canonical = 0; fire("R6 non-canonical 64-bit", 2'd2);
        base_ok(); size64 = 0; cpu_mode = 3'd3; addr_canonical = 0;
        fire("R6 flag ignored in compat", 2'd0);
    endtask

    task automatic t_page();
        base_ok(); pg_shadow = 0; fire("R7 non-shadow page", 2'd3);
        base_ok(); pg_user = 0; fire("R7 supervisor page at level 3", 2'd3);
        base_ok(); cpl = 2'd1; sup_stk_en = 1; sup_wr_en = 1; fire("R7 user page at level 1", 2'd3);
    endtask

    task automatic t_priority();
        base_ok(); lock_pfx = 1; dest_addr = 64'h1001; pg_shadow = 0;
        fire("R8 ud over gp and pf", 2'd1);
        base_ok(); dest_addr = 64'h1003; pg_shadow = 0; fire("R8 gp over pf", 2'd2);
    endtask

    task automatic t_store();
        base_ok(); size64 = 0; dest_addr = 64'h2008; fire("R9 4-byte", 2'd0);
        chk("R9 be 4-byte", {56'd0, store_be}, 64'h0F);
        chk("R9 data 4-byte", store_data, 64'h0000_0000_5566_7788);
        chk("R9 addr", store_addr, 64'h2008);
        base_ok(); fire("R9 8-byte", 2'd0);
        chk("R9 be 8-byte", {56'd0, store_be}, 64'hFF);
        chk("R9 data 8-byte", store_data, 64'h1122_3344_5566_7788);
    endtask

    task automatic t_idle();
        base_ok(); fire("R10 pulse", 2'd0);
        @(negedge clk);
        chk("R10 done drops", {63'd0, done}, 0);
        chk("R10 store drops", {63'd0, store_valid}, 0);
    endtask

    initial begin
        base_ok();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_select(); t_enables(); t_mode_lock(); t_align(); t_canon();
        t_page(); t_priority(); t_store(); t_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule